// File: doc/BRIEF.md
# Sample-Sequence Output Checker

This block watches one data stream coming out of a circuit under test and compares it, one clock cycle at a time, against an ordered list of expected words. The list is fixed when the block is built and is passed in as a parameter. Each cycle the block compares the observed word with the list entry at its current position, then moves one position on. It exposes the current expected word and its position so a log can show what was wanted. A mismatch raises a strobe for that cycle and is added to a running error count. Checking then carries on with the next entry.

The position register is held at the first entry while reset is high. The first expected word is therefore compared both in the reset cycle and in the first cycle after reset. After the last entry has been checked, a completion flag rises and stays high until the next reset. From then on the position stays on the last entry and no further mismatches are flagged or counted. A build option adds a per-entry care mask: bits cleared in an entry's mask are ignored in that entry's compare. A simulation-only message reports each counted mismatch with its time, position, expected word and observed word.

Top module: `sample_seq_checker`

## Requirements
- R1: In the unmasked build, `mismatch` is high in a cycle exactly when `obs_data` differs from the expected word at the current position (while `done` is low), as a combinational result of that same cycle.
- R2: `exp_index` shows the current position and `exp_data` shows the table word at that position; out of reset the position rises by one at every clock edge until it reaches DEPTH-1.
- R3: A clock edge with `rst` high (synchronous, active high) sets the position to 0, `done` to 0 and `err_count` to 0. The compare still drives `mismatch` while `rst` is high, but such cycles are never counted.
- R4: Entry 0 is compared in the reset cycle and again in the first cycle after `rst` falls, because the position is still 0 in that cycle.
- R5: `done` is low while entries remain unchecked. It becomes high in the cycle after the cycle in which entry DEPTH-1 was compared.
- R6: Once `done` is high it stays high until reset, the position stays at DEPTH-1, and `mismatch` is held low whatever `obs_data` is.
- R7: `err_count` rises by exactly one after each non-reset cycle with `mismatch` high. Its width is sized from DEPTH so it can never wrap.
- R8: In the masked build, bit b of entry i is compared only when bit b of that entry's care mask is 1. Differences in bits whose mask bit is 0 never raise `mismatch`.
- R9: A mismatch does not stop checking: the following entries are compared and reported exactly as if no mismatch had occurred.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| obs_data | input | DATA_W | Word observed from the circuit under test |
| mismatch | output | 1 | High in a cycle whose compare failed |
| exp_data | output | DATA_W | Expected word at the current position |
| exp_index | output | IDX_W | Current table position |
| done | output | 1 | All entries have been checked |
| err_count | output | ERR_W | Number of counted mismatches since reset |

## Verification
On every cycle the embedded assertions check four things. The position steps by one and saturates. Reset clears the position, `done` and the count. `done` rises only after the last entry and never falls outside reset. The error count grows by one per counted mismatch and never reaches a wrap. Only the bench's scenarios can show the compare values themselves. These are the exact cycles in which `mismatch` fires, the double check of entry 0 around reset, and that don't-care bits are ignored. The bench sweeps every corrupt/clean pattern over a four-entry table, for both the plain and the masked build.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
   // Width needed to hold values 0 .. n-1, never below one bit.
   function automatic int unsigned ssc_bits(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/ssc_index_seq.sv
module ssc_index_seq #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned IDX_W = 2
) (
   input  logic             clk,
   input  logic             rst,
   output logic [IDX_W-1:0] idx,
   output logic             done
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

   logic at_last;
   assign at_last = (idx == LAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         idx  <= '0;
         done <= 1'b0;
      end else begin
         if (!at_last) idx <= idx + 1'b1;
         if (at_last)  done <= 1'b1;
      end
   end

   a_r2_step: assert property (@(posedge clk) disable iff (rst)
      (!at_last) |=> (idx == $past(idx) + 1'b1));
   a_r3_reset_clear: assert property (@(posedge clk)
      rst |=> (idx == '0 && !done));
   a_r5_done_after_last: assert property (@(posedge clk) disable iff (rst)
      $rose(done) |-> ($past(idx) == LAST));
   a_r6_done_sticky: assert property (@(posedge clk) disable iff (rst)
      done |=> (done && idx == LAST));
endmodule

// File: rtl/ssc_compare.sv
module ssc_compare #(
   parameter int unsigned DATA_W   = 8,
   parameter bit          USE_MASK = 1'b0
) (
   input  logic [DATA_W-1:0] obs,
   input  logic [DATA_W-1:0] expv,
   input  logic [DATA_W-1:0] care,
   output logic              differ
);
   logic [DATA_W-1:0] diff_bits;

   generate
      if (USE_MASK) begin : g_masked
         assign diff_bits = (obs ^ expv) & care;
      end else begin : g_plain
         logic unused_care;
         assign unused_care = ^care;
         assign diff_bits   = obs ^ expv;
      end
   endgenerate

   assign differ = |diff_bits;
endmodule

// File: rtl/ssc_err_count.sv
module ssc_err_count #(
   parameter int unsigned ERR_W = 3,
   parameter int unsigned LIMIT = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             inc,
   output logic [ERR_W-1:0] cnt
);
   always_ff @(posedge clk) begin
      if (rst)      cnt <= '0;
      else if (inc) cnt <= cnt + 1'b1;
   end

   a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
      inc |-> (cnt < ERR_W'(LIMIT)));
   a_r7_count_step: assert property (@(posedge clk) disable iff (rst)
      inc |=> (cnt == $past(cnt) + 1'b1));
   a_r7_count_hold: assert property (@(posedge clk) disable iff (rst)
      !inc |=> $stable(cnt));
endmodule

// File: rtl/sample_seq_checker.sv
module sample_seq_checker
   import ssc_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned DEPTH    = 4,
   parameter bit          USE_MASK = 1'b0,
   parameter logic [DEPTH*DATA_W-1:0] EXP_TABLE  = '0,
   parameter logic [DEPTH*DATA_W-1:0] CARE_TABLE = '1,
   localparam int unsigned IDX_W = ssc_bits(DEPTH),
   localparam int unsigned ERR_W = ssc_bits(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] obs_data,
   output logic              mismatch,
   output logic [DATA_W-1:0] exp_data,
   output logic [IDX_W-1:0]  exp_index,
   output logic              done,
   output logic [ERR_W-1:0]  err_count
);
   generate
      if (DEPTH < 1)  begin : g_bad_depth  $error("DEPTH must be at least 1"); end
      if (DATA_W < 1) begin : g_bad_width  $error("DATA_W must be at least 1"); end
   endgenerate

   logic [IDX_W-1:0]  idx;
   logic              fin;
   logic [DATA_W-1:0] care_word;
   logic              differ;

   ssc_index_seq #(.DEPTH(DEPTH), .IDX_W(IDX_W)) seq_i (
      .clk (clk),
      .rst (rst),
      .idx (idx),
      .done(fin)
   );

   assign exp_data  = EXP_TABLE[idx*DATA_W +: DATA_W];
   assign care_word = CARE_TABLE[idx*DATA_W +: DATA_W];

   ssc_compare #(.DATA_W(DATA_W), .USE_MASK(USE_MASK)) cmp_i (
      .obs   (obs_data),
      .expv  (exp_data),
      .care  (care_word),
      .differ(differ)
   );

   assign mismatch  = differ && !fin;
   assign exp_index = idx;
   assign done      = fin;

   ssc_err_count #(.ERR_W(ERR_W), .LIMIT(DEPTH)) cnt_i (
      .clk(clk),
      .rst(rst),
      .inc(mismatch && !rst),
      .cnt(err_count)
   );

   always_ff @(posedge clk) begin
      if (!rst && mismatch)
         $display("ssc mismatch t=%0t entry=%0d expected=%h observed=%h",
                  $time, idx, exp_data, obs_data);
   end

   a_r6_quiet_after_done: assert property (@(posedge clk) disable iff (rst)
      done |-> !mismatch);
endmodule

// File: tb/sample_seq_checker_tb_top.sv
module sample_seq_checker_tb_top;
   localparam int unsigned DW = 8;
   localparam int unsigned DP = 4;

   function automatic logic [DW-1:0] exp_val(input int i);
      return 8'h5A + 8'(8'h33 * i);
   endfunction
   function automatic logic [DW-1:0] care_val(input int i);
      return 8'hF0 >> i;
   endfunction
   function automatic logic [DP*DW-1:0] pack_exp();
      logic [DP*DW-1:0] v;
      for (int i = 0; i < DP; i++) v[i*DW +: DW] = exp_val(i);
      return v;
   endfunction
   function automatic logic [DP*DW-1:0] pack_care();
      logic [DP*DW-1:0] v;
      for (int i = 0; i < DP; i++) v[i*DW +: DW] = care_val(i);
      return v;
   endfunction

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [DW-1:0] obs_a = '0, obs_b = '0;
   logic mm_a, mm_b, dn_a, dn_b;
   logic [DW-1:0] ed_a, ed_b;
   logic [1:0] ix_a, ix_b;
   logic [2:0] ec_a, ec_b;
   int checks = 0, errors = 0;

   always #2 clk = ~clk;

   sample_seq_checker #(.DATA_W(DW), .DEPTH(DP), .USE_MASK(1'b0),
      .EXP_TABLE(pack_exp()), .CARE_TABLE(pack_care())) dut_i (
      .clk(clk), .rst(rst), .obs_data(obs_a), .mismatch(mm_a),
      .exp_data(ed_a), .exp_index(ix_a), .done(dn_a), .err_count(ec_a));

   sample_seq_checker #(.DATA_W(DW), .DEPTH(DP), .USE_MASK(1'b1),
      .EXP_TABLE(pack_exp()), .CARE_TABLE(pack_care())) dut_mask_i (
      .clk(clk), .rst(rst), .obs_data(obs_b), .mismatch(mm_b),
      .exp_data(ed_b), .exp_index(ix_b), .done(dn_b), .err_count(ec_b));

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] expd);
      checks++;
      if (act !== expd) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expd);
      end
   endtask

   task automatic run_pass(input int pat);
      int nbad;
      nbad = 0;
      rst = 1'b1;
      @(posedge clk); @(negedge clk);
      // reset cycle: entry 0 compared, nothing counted
      obs_a = exp_val(0) ^ 8'h10;
      obs_b = exp_val(0) ^ 8'h10;
      #1;
      chk("R3", "reset idx", 32'(ix_a), 0);
      chk("R3", "reset done", 32'(dn_a), 0);
      chk("R3", "reset count", 32'(ec_a), 0);
      chk("R4", "reset-cycle compare plain", 32'(mm_a), 1);
      chk("R4", "reset-cycle compare masked", 32'(mm_b), 1);
      @(posedge clk); @(negedge clk);
      rst = 1'b0;
      for (int i = 0; i < DP; i++) begin
         logic bad;
         bad = pat[i];
         obs_a = bad ? (exp_val(i) ^ (8'h10 >> i)) : exp_val(i);
         obs_b = bad ? (exp_val(i) ^ (8'h10 >> i)) : (exp_val(i) ^ ~care_val(i));
         #1;
         chk("R2", "index", 32'(ix_a), 32'(i));
         chk("R2", "expected word", 32'(ed_a), 32'(exp_val(i)));
         chk("R5", "done low mid-run", 32'(dn_a), 0);
         chk("R1", "plain compare", 32'(mm_a), 32'(bad));
         chk("R8", "masked compare", 32'(mm_b), 32'(bad));
         chk("R9", "count so far", 32'(ec_a), 32'(nbad));
         chk("R7", "masked count so far", 32'(ec_b), 32'(nbad));
         if (bad) nbad++;
         @(posedge clk); @(negedge clk);
      end
      obs_a = ~exp_val(DP-1);
      obs_b = ~exp_val(DP-1);
      #1;
      chk("R5", "done after last", 32'(dn_a), 1);
      chk("R5", "masked done after last", 32'(dn_b), 1);
      chk("R7", "final count", 32'(ec_a), 32'(nbad));
      chk("R6", "quiet after done", 32'(mm_a), 0);
      chk("R6", "idx saturated", 32'(ix_a), DP-1);
      @(posedge clk); @(negedge clk);
      #1;
      chk("R6", "done sticky", 32'(dn_a), 1);
      chk("R6", "idx still last", 32'(ix_b), DP-1);
      chk("R6", "count frozen", 32'(ec_b), 32'(nbad));
   endtask

   initial begin
      for (int p = 0; p < 16; p++) run_pass(p);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule